// File: doc/BRIEF.md
# Center-Aligned PWM Generator with Split Compare Loading

This block produces one center-aligned PWM output from a time-base counter that climbs from zero to a programmable period and then falls back to zero. Counter events (zero, period, and two compare values, each split by count direction) select 2-bit actions that drive the output low, high, or toggle it. Period and compare values are written into shadow copies. They move to the active copies only on a counter event.

The compare has a coarse part, which sets the clock-cycle position of an edge, and a fine part, which counts sub-cycle delay steps. The two parts have independent load-event selects. On every output transition the block raises a one-cycle strobe and reports the fine value that applied at that instant. It reports the value only when the edge mode picks that kind of edge. A downstream delay stage uses this report to shift the edge inside the clock period. If the fine value is loaded on the wrong event, the stale value lands on the edge, and the report shows it.

All settings arrive through a small register-write port.

Top module: `cpwm_top`

## Requirements
- R1: The counter steps by one per clock from 0 up to the active period and back down to 0, so the output pattern repeats every 2*period clocks. A compare match at the period counts as up-counting, and a match at zero counts as down-counting.
- R2: An action code of 0 leaves the output unchanged, 1 drives it low, 2 drives it high and 3 toggles it. `pwm_o` shows the result one clock after the counter holds the matching value.
- R3: The action register (address 4, bits [11:0]) holds six 2-bit codes, listed from the least significant end: zero [1:0], period [3:2], compare A up [5:4], compare A down [7:6], compare B up [9:8], compare B down [11:10].
- R4: When several events with a non-zero code fall in the same clock, the highest-priority one decides the action. Priority from highest to lowest is period, zero, compare B, compare A.
- R5: The register map is: address 0 period, address 1 compare A, address 2 compare B, address 3 fine field. Writes to these four addresses change only shadow copies. An active copy changes only on its load event, so a write between events does not alter the waveform until that event.
- R6: The active period loads from its shadow whenever the counter is at zero. Compare A and compare B load according to the coarse select, which is config (address 5) bits [1:0]: 0 loads at zero, 1 loads at period, 2 or 3 loads at both.
- R7: The fine value is the upper byte of the 16-bit fine field, so writing N<<8 gives N steps. It loads according to the fine select, config bits [3:2], which uses the same codes as the coarse select and acts independently of it.
- R8: On each clock where `pwm_o` changes, `edge_stb_o` is high for one cycle. The edge mode is config bits [5:4]: 0 selects no edge, 1 the rising edge, 2 the falling edge, 3 both edges. When the edge is selected, `edge_sel_o` is high and `edge_fine_o` carries the fine value that was active when the event occurred. Otherwise both are 0.
- R9: Reset clears every shadow, active and configuration register, drives `pwm_o` low, and holds the edge outputs at 0.
- R10: While the active period is zero, the counter holds at zero and no action event fires, so the output keeps its level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| pwm_o | output | 1 | PWM output |
| edge_stb_o | output | 1 | One-cycle strobe on each output transition |
| edge_sel_o | output | 1 | High when the edge mode selects the current transition |
| edge_fine_o | output | 8 | Fine steps for the current transition, or 0 |

## Verification
The assertions take two things for granted. First, the period only changes through its zero-event load, so the counter never sits above the active period while it is running. Second, the compare values lie within 0 to the period. The stimulus respects both. It writes compare values inside that range, and it writes new coarse or fine values only in the middle of an output pulse, well away from any load event or edge. Every scenario begins from a fresh reset, so no configuration carries over from one scenario to the next.

// File: rtl/cpwm_pkg.sv
package cpwm_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_PERIOD = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMPA   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMPB   = 3'd2;
  localparam logic [ADDR_W-1:0] A_FINE   = 3'd3;
  localparam logic [ADDR_W-1:0] A_ACTION = 3'd4;
  localparam logic [ADDR_W-1:0] A_CONFIG = 3'd5;

  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_LOW    = 2'd1,
    ACT_HIGH   = 2'd2,
    ACT_TOGGLE = 2'd3
  } act_e;

  // zero action sits at the least significant end
  typedef struct packed {
    act_e cbd;
    act_e cbu;
    act_e cad;
    act_e cau;
    act_e prd;
    act_e zro;
  } act_t;

  localparam int ACT_W = $bits(act_t);

  typedef struct packed {
    logic [1:0] emode;
    logic [1:0] fsel;
    logic [1:0] csel;
  } cfg_t;

  localparam int CFG_W = $bits(cfg_t);

  // load-event decode shared by coarse and fine selects
  function automatic logic load_hit(input logic [1:0] sel, input logic z, input logic p);
    case (sel)
      2'd0:    return z;
      2'd1:    return p;
      default: return z | p;
    endcase
  endfunction

  function automatic logic apply_act(input act_e a, input logic cur);
    case (a)
      ACT_LOW:    return 1'b0;
      ACT_HIGH:   return 1'b1;
      ACT_TOGGLE: return ~cur;
      default:    return cur;
    endcase
  endfunction

endpackage

// File: rtl/cpwm_timebase.sv
module cpwm_timebase #(
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] per_i,
  output logic [CW-1:0] ctr_o,
  output logic          dir_up_o,
  output logic          at_zero_o,
  output logic          at_per_o,
  output logic          run_o
);

  localparam logic [CW-1:0] ONE = CW'(1);

  logic [CW-1:0] ctr_q, ctr_d;
  logic          dir_q, dir_d;

  // next state: dir_q is the direction that produced the current count
  always_comb begin
    ctr_d = ctr_q;
    dir_d = dir_q;
    if (per_i == '0) begin
      ctr_d = '0;
      dir_d = 1'b0;
    end else if (dir_q) begin
      if (ctr_q >= per_i) begin
        ctr_d = ctr_q - ONE;
        dir_d = 1'b0;
      end else begin
        ctr_d = ctr_q + ONE;
      end
    end else begin
      if (ctr_q == '0) begin
        ctr_d = ONE;
        dir_d = 1'b1;
      end else begin
        ctr_d = ctr_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctr_q <= '0;
      dir_q <= 1'b0;
    end else begin
      ctr_q <= ctr_d;
      dir_q <= dir_d;
    end
  end

  assign ctr_o     = ctr_q;
  assign dir_up_o  = dir_q;
  assign at_zero_o = (ctr_q == '0);
  assign at_per_o  = (ctr_q == per_i);
  assign run_o     = (per_i != '0);

  AST_CTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ctr_q != '0) |=> (ctr_q == $past(ctr_q) + ONE) || (ctr_q == $past(ctr_q) - ONE)); // R1

  AST_TURN_AT_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
    (per_i != '0 && ctr_q == per_i) |=> (ctr_q < $past(ctr_q))); // R1

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (per_i == '0) |=> (ctr_q == '0)); // R10

endmodule

// File: rtl/cpwm_regs.sv
module cpwm_regs
  import cpwm_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic              at_zero_i,
  input  logic              at_per_i,
  output logic [CW-1:0]     per_o,
  output logic [CW-1:0]     cmpa_o,
  output logic [CW-1:0]     cmpb_o,
  output logic [FW-1:0]     fine_o,
  output act_t              act_o,
  output logic [1:0]        emode_o
);

  logic [CW-1:0] per_sh_q, cmpa_sh_q, cmpb_sh_q;
  logic [FW-1:0] fine_sh_q;
  logic [CW-1:0] per_q, cmpa_q, cmpb_q;
  logic [FW-1:0] fine_q;
  act_t          act_q;
  cfg_t          cfg_q;

  logic wr_per, wr_cmpa, wr_cmpb, wr_fine, wr_act, wr_cfg;
  logic ld_per, ld_crs, ld_fin;

  // write decode and load-event enables
  always_comb begin
    wr_per  = wr_en && (wr_addr == A_PERIOD);
    wr_cmpa = wr_en && (wr_addr == A_CMPA);
    wr_cmpb = wr_en && (wr_addr == A_CMPB);
    wr_fine = wr_en && (wr_addr == A_FINE);
    wr_act  = wr_en && (wr_addr == A_ACTION);
    wr_cfg  = wr_en && (wr_addr == A_CONFIG);
    ld_per  = at_zero_i;
    ld_crs  = load_hit(cfg_q.csel, at_zero_i, at_per_i);
    ld_fin  = load_hit(cfg_q.fsel, at_zero_i, at_per_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sh_q  <= '0;
      cmpa_sh_q <= '0;
      cmpb_sh_q <= '0;
      fine_sh_q <= '0;
      act_q     <= '0;
      cfg_q     <= '0;
    end else begin
      if (wr_per)  per_sh_q  <= wr_data[CW-1:0];
      if (wr_cmpa) cmpa_sh_q <= wr_data[CW-1:0];
      if (wr_cmpb) cmpb_sh_q <= wr_data[CW-1:0];
      if (wr_fine) fine_sh_q <= wr_data[DW-1 -: FW];
      if (wr_act)  act_q     <= act_t'(wr_data[ACT_W-1:0]);
      if (wr_cfg)  cfg_q     <= cfg_t'(wr_data[CFG_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_q  <= '0;
      cmpa_q <= '0;
      cmpb_q <= '0;
      fine_q <= '0;
    end else begin
      if (ld_per) per_q <= per_sh_q;
      if (ld_crs) begin
        cmpa_q <= cmpa_sh_q;
        cmpb_q <= cmpb_sh_q;
      end
      if (ld_fin) fine_q <= fine_sh_q;
    end
  end

  assign per_o   = per_q;
  assign cmpa_o  = cmpa_q;
  assign cmpb_o  = cmpb_q;
  assign fine_o  = fine_q;
  assign act_o   = act_q;
  assign emode_o = cfg_q.emode;

  AST_ACTIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(at_zero_i || at_per_i) |=> ($stable(cmpa_o) && $stable(cmpb_o) && $stable(fine_o))); // R5

  AST_PERIOD_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !at_zero_i |=> $stable(per_o)); // R6

endmodule

// File: rtl/cpwm_action.sv
module cpwm_action
  import cpwm_pkg::*;
#(
  parameter int CW = 16,
  parameter int FW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] ctr_i,
  input  logic          dir_up_i,
  input  logic          at_zero_i,
  input  logic          at_per_i,
  input  logic          run_i,
  input  logic [CW-1:0] cmpa_i,
  input  logic [CW-1:0] cmpb_i,
  input  logic [FW-1:0] fine_i,
  input  act_t          act_i,
  input  logic [1:0]    emode_i,
  output logic          pwm_o,
  output logic          edge_stb_o,
  output logic          edge_sel_o,
  output logic [FW-1:0] edge_fine_o
);

  logic          out_q, out_d;
  logic          stb_q, sel_q;
  logic [FW-1:0] fine_q;

  logic ev_zro, ev_prd, ev_cau, ev_cad, ev_cbu, ev_cbd;
  act_e act_sel;
  logic rise, fall, chg, pick;

  always_comb begin
    ev_zro = run_i && at_zero_i;
    ev_prd = run_i && at_per_i;
    ev_cau = run_i &&  dir_up_i && (ctr_i == cmpa_i);
    ev_cad = run_i && !dir_up_i && (ctr_i == cmpa_i);
    ev_cbu = run_i &&  dir_up_i && (ctr_i == cmpb_i);
    ev_cbd = run_i && !dir_up_i && (ctr_i == cmpb_i);

    // lowest priority first, later lines override
    act_sel = ACT_NONE;
    if (ev_cau && act_i.cau != ACT_NONE) act_sel = act_i.cau;
    if (ev_cad && act_i.cad != ACT_NONE) act_sel = act_i.cad;
    if (ev_cbu && act_i.cbu != ACT_NONE) act_sel = act_i.cbu;
    if (ev_cbd && act_i.cbd != ACT_NONE) act_sel = act_i.cbd;
    if (ev_zro && act_i.zro != ACT_NONE) act_sel = act_i.zro;
    if (ev_prd && act_i.prd != ACT_NONE) act_sel = act_i.prd;

    out_d = apply_act(act_sel, out_q);
    rise  =  out_d && !out_q;
    fall  = !out_d &&  out_q;
    chg   = rise || fall;
    case (emode_i)
      2'd1:    pick = rise;
      2'd2:    pick = fall;
      2'd3:    pick = chg;
      default: pick = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      stb_q  <= 1'b0;
      sel_q  <= 1'b0;
      fine_q <= '0;
    end else begin
      out_q  <= out_d;
      stb_q  <= chg;
      sel_q  <= pick;
      fine_q <= pick ? fine_i : '0;
    end
  end

  assign pwm_o       = out_q;
  assign edge_stb_o  = stb_q;
  assign edge_sel_o  = sel_q;
  assign edge_fine_o = fine_q;

  AST_STB_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_o != $past(pwm_o)) |-> edge_stb_o); // R8

  AST_QUIET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> $stable(pwm_o)); // R10

  AST_PRD_LOW_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && at_per_i && act_i.prd == ACT_LOW) |=> !pwm_o); // R4

  AST_PRD_HIGH_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && at_per_i && act_i.prd == ACT_HIGH) |=> pwm_o); // R4

endmodule

// File: rtl/cpwm_top.sv
module cpwm_top
  import cpwm_pkg::*;
#(
  parameter int DW = 16,
  parameter int CW = 16,
  parameter int FW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  output logic              pwm_o,
  output logic              edge_stb_o,
  output logic              edge_sel_o,
  output logic [FW-1:0]     edge_fine_o
);

  logic [1:0]    rst_sync_q;
  logic          rst_sn;
  logic [CW-1:0] per, cmpa, cmpb, ctr;
  logic [FW-1:0] fine;
  act_t          act;
  logic [1:0]    emode;
  logic          dir_up, at_zero, at_per, run;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sn = rst_sync_q[1];

  cpwm_timebase #(.CW(CW)) u_tb (
    .clk      (clk),
    .rst_n    (rst_sn),
    .per_i    (per),
    .ctr_o    (ctr),
    .dir_up_o (dir_up),
    .at_zero_o(at_zero),
    .at_per_o (at_per),
    .run_o    (run)
  );

  cpwm_regs #(.DW(DW), .CW(CW), .FW(FW)) u_regs (
    .clk      (clk),
    .rst_n    (rst_sn),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .at_zero_i(at_zero),
    .at_per_i (at_per),
    .per_o    (per),
    .cmpa_o   (cmpa),
    .cmpb_o   (cmpb),
    .fine_o   (fine),
    .act_o    (act),
    .emode_o  (emode)
  );

  cpwm_action #(.CW(CW), .FW(FW)) u_act (
    .clk        (clk),
    .rst_n      (rst_sn),
    .ctr_i      (ctr),
    .dir_up_i   (dir_up),
    .at_zero_i  (at_zero),
    .at_per_i   (at_per),
    .run_i      (run),
    .cmpa_i     (cmpa),
    .cmpb_i     (cmpb),
    .fine_i     (fine),
    .act_i      (act),
    .emode_i    (emode),
    .pwm_o      (pwm_o),
    .edge_stb_o (edge_stb_o),
    .edge_sel_o (edge_sel_o),
    .edge_fine_o(edge_fine_o)
  );

endmodule

// File: tb/cpwm_top_bench.sv
module cpwm_top_bench;
  import cpwm_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic        pwm_o, edge_stb_o, edge_sel_o;
  logic [7:0]  edge_fine_o;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  cpwm_top u_cpwm_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .pwm_o(pwm_o), .edge_stb_o(edge_stb_o), .edge_sel_o(edge_sel_o), .edge_fine_o(edge_fine_o)
  );

  typedef struct packed {
    int per; int cmpa; int cmpb; int act; int hi; int lo;
  } vec_t;

  // R1 R2 R3: widths follow from period, compare and action field placement
  localparam vec_t VECS [8] = '{
    '{200, 50,  0, 'h090, 100, 300},
    '{200, 50,  0, 'h060, 300, 100},
    '{100, 30,  0, 'h060, 140,  60},
    '{ 10,  5,  0, 'h090,  10,  10},
    '{ 40,  0,  0, 'h006,  40,  40},
    '{ 50,  0, 20, 'h600,  60,  40},
    '{ 20,  0,  0, 'h003,  40,  40},
    '{200,199,  0, 'h060,   2, 398}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0; wr_en = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic setup(input int per, input int ca, input int cb, input int act,
                       input int csel, input int fsel, input int emode);
    wr(A_CONFIG, 16'(csel | (fsel << 2) | (emode << 4)));
    wr(A_ACTION, 16'(act));
    wr(A_CMPA, 16'(ca));
    wr(A_CMPB, 16'(cb));
    wr(A_PERIOD, 16'(per));
  endtask

  task automatic wait_edge(input logic lvl);
    logic p;
    p = pwm_o;
    forever begin
      @(negedge clk);
      if (pwm_o == lvl && p != lvl) break;
      p = pwm_o;
    end
  endtask

  task automatic wait_stb();
    do @(negedge clk); while (!edge_stb_o);
  endtask

  task automatic measure(output int hi, output int lo);
    wait_edge(1'b1);
    hi = 1;
    forever begin @(negedge clk); if (pwm_o) hi++; else break; end
    lo = 1;
    forever begin @(negedge clk); if (!pwm_o) lo++; else break; end
  endtask

  task automatic count_high_after(input int start, output int n);
    n = start;
    forever begin @(negedge clk); if (pwm_o) n++; else break; end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL R1 watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, lo, n;
    do_reset();

    // R9: outputs quiet right after reset
    chk("R9 pwm after reset", int'(pwm_o), 0);
    chk("R9 strobe after reset", int'(edge_stb_o), 0);

    // table walk
    foreach (VECS[i]) begin
      do_reset();
      setup(VECS[i].per, VECS[i].cmpa, VECS[i].cmpb, VECS[i].act, 0, 0, 0);
      wait_edge(1'b1);
      measure(hi, lo);
      chk($sformatf("R2 vec%0d high", i), hi, VECS[i].hi);
      chk($sformatf("R1 vec%0d low", i), lo, VECS[i].lo);
    end

    // R10: zero period suppresses all events
    do_reset();
    wr(A_ACTION, 16'hAAA);
    n = 0;
    repeat (50) begin @(negedge clk); if (pwm_o) n++; end
    chk("R10 no action while period zero", n, 0);
    wr(A_PERIOD, 16'd20);
    repeat (60) @(negedge clk);
    chk("R10 runs once period set", int'(pwm_o), 1);

    // R4: period beats compare A at the same count
    do_reset();
    setup(30, 30, 0, 'h024, 0, 0, 0);
    n = 0;
    repeat (200) begin @(negedge clk); if (pwm_o) n++; end
    chk("R4 period over compare A", n, 0);

    // R4: compare B beats compare A
    do_reset();
    setup(30, 10, 10, 'h120, 0, 0, 0);
    n = 0;
    repeat (200) begin @(negedge clk); if (pwm_o) n++; end
    chk("R4 compare B over compare A", n, 0);

    // R4: zero beats compare B down at count zero
    do_reset();
    setup(30, 0, 0, 'h402, 0, 0, 0);
    repeat (100) @(negedge clk);
    n = 0;
    repeat (200) begin @(negedge clk); if (!pwm_o) n++; end
    chk("R4 zero over compare B", n, 0);

    // R5 R6: coarse compare loaded at zero gives asymmetric pulse
    do_reset();
    setup(200, 50, 0, 'h090, 0, 0, 0);
    wait_edge(1'b1); wait_edge(1'b1);
    wr(A_CMPA, 16'd100);
    count_high_after(2, n);
    chk("R6 coarse load at zero", n, 150);
    measure(hi, lo);
    chk("R5 next pulse uses new compare", hi, 200);

    // R6: coarse compare loaded at period keeps pulse symmetric
    do_reset();
    setup(200, 50, 0, 'h090, 1, 0, 0);
    wait_edge(1'b1); wait_edge(1'b1);
    wr(A_CMPA, 16'd100);
    count_high_after(2, n);
    chk("R6 coarse load at period", n, 100);

    // R7 R8: falling-edge fine, falling on up-count, fine loads at zero
    do_reset();
    setup(200, 50, 0, 'h090, 0, 0, 2);
    wait_edge(1'b1); wait_edge(1'b1);
    wr(A_FINE, 16'(130 << 8));
    wait_stb();
    chk("R8 first strobe is falling", int'(pwm_o), 0);
    chk("R7 fine at zero reaches edge", int'(edge_fine_o), 130);
    chk("R8 falling selected", int'(edge_sel_o), 1);
    wait_stb();
    chk("R8 rising not selected value", int'(edge_fine_o), 0);
    chk("R8 rising not selected flag", int'(edge_sel_o), 0);

    // R7: same setup with fine loaded at period leaves stale value on edge
    do_reset();
    setup(200, 50, 0, 'h090, 0, 1, 2);
    wait_edge(1'b1); wait_edge(1'b1);
    wr(A_FINE, 16'(130 << 8));
    wait_stb();
    chk("R7 period load misses falling edge", int'(edge_fine_o), 0);
    wait_stb(); wait_stb();
    chk("R7 value appears one edge late", int'(edge_fine_o), 130);

    // R7: opposite actions put falling edge on down-count, period load fits
    do_reset();
    setup(200, 50, 0, 'h060, 0, 1, 2);
    wait_edge(1'b1); wait_edge(1'b1);
    wr(A_FINE, 16'(200 << 8));
    wait_stb();
    chk("R7 down-count falling edge value", int'(edge_fine_o), 200);

    // R7 R8: both edges with load on both events
    do_reset();
    setup(200, 50, 0, 'h090, 0, 2, 3);
    wait_edge(1'b1); wait_edge(1'b1);
    wr(A_FINE, 16'(77 << 8));
    wait_stb();
    chk("R8 both mode falling", int'(edge_fine_o), 77);
    wait_stb();
    chk("R8 both mode rising", int'(edge_fine_o), 77);
    chk("R8 both mode rising flag", int'(edge_sel_o), 1);

    // R9: reset in the middle of a high pulse
    do_reset();
    setup(40, 0, 0, 'h006, 0, 0, 3);
    wait_edge(1'b1);
    rst_n = 1'b0;
    #1;
    chk("R9 pwm cleared by reset", int'(pwm_o), 0);
    chk("R9 fine cleared by reset", int'(edge_fine_o), 0);
    @(negedge clk);
    rst_n = 1'b1;
    n = 0;
    repeat (120) begin @(negedge clk); if (pwm_o) n++; end
    chk("R9 settings cleared by reset", n, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule